// File: doc/BRIEF.md
# Dual Timer/Counter with Four Counting Modes

This block holds two 16-bit up-counters, timer 0 and timer 1. Each is kept as a low byte and a high byte. An 8-bit configuration register gives each timer a gate enable, a count-source select and a two-bit mode. A 4-bit control register holds each timer's run bit and overflow flag. A timer counts either machine ticks or falling edges on its external count pin. A machine tick is one pulse every `TICK_DIV` clock cycles. Four modes are available: a 13-bit counter built from a 5-bit prescaler and an 8-bit high byte, a plain 16-bit counter, an 8-bit counter that reloads from the high byte, and a split mode. In split mode timer 0 becomes two independent 8-bit counters.

Software loads the registers through a one-cycle write strobe with a 3-bit address. Address 0 is the configuration register, 1 the control register, 2 and 3 the low and high bytes of timer 0, and 4 and 5 those of timer 1. All register contents appear on output ports. Each overflow flag can also be cleared by an acknowledge input from an interrupt controller. Timer 1's overflow is also sent out as a one-clock pulse, which can be used to generate a baud rate. There is no streaming data path: every pin is a plain control or status signal.

Top module: `tmr_pair`

## Requirements
- R1: After reset the configuration register, the control register, both 16-bit counts and `ovf_pulse1` are all zero.
- R2: Configuration nibble layout: timer 0 uses bits 3:0 and timer 1 uses bits 7:4. In each nibble, bit 3 is the gate enable, bit 2 selects the external count source, and bits 1:0 give the mode. Control layout: bit 0 is run 0, bit 1 is flag 0, bit 2 is run 1, bit 3 is flag 1. A register write takes effect on the next clock edge and takes priority over counting in that register. With the internal source selected, an enabled timer advances once per machine tick, that is, once every `TICK_DIV` clocks.
- R3: Mode 0 (13-bit): bits 4:0 of the low byte form a prescaler. When the prescaler passes 31 it wraps to 0 and the high byte increments. Bits 7:5 of the low byte are never changed by counting. An overflow occurs when the high byte is 0xFF and the prescaler is 31.
- R4: Mode 1 (16-bit): the count runs from 0xFFFF to 0x0000, and that step is an overflow.
- R5: Mode 2 (reload): only the low byte counts. Stepping from 0xFF loads the high byte into the low byte and is an overflow. The high byte itself is never changed by counting.
- R6: Mode 3 on timer 0: the low byte is an 8-bit counter that uses timer 0's gate, source, run bit and flag 0.
- R7: Mode 3 on timer 0: the high byte counts machine ticks while run 1 is set, and its overflow sets flag 1. While timer 0 is split, timer 1 ignores run 1 and counts whenever its gate allows. It never sets flag 1 in this state, but its overflow still drives `ovf_pulse1`.
- R8: Timer 1 set to mode 3 holds its count.
- R9: A timer with its gate bit set counts only while its run bit and its `gate_in` pin are both high. With the gate bit clear, the run bit alone enables it. Timer 1 while timer 0 is split is the exception covered by R7.
- R10: With the external source selected, the pin is sampled once per machine tick. A count occurs on the tick at which the previous two samples were 1 and then 0, so one high-to-low transition counts once.
- R11: A flag is set on its overflow. It is cleared by a control-register write of 0 to that bit, or by its `ack` input. An overflow in the same cycle as a clear wins.
- R12: `ovf_pulse1` is high for exactly one clock, the clock after each timer 1 overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 config, 1 control, 2..5 count bytes) |
| wr_data | input | 8 | Write data |
| ack | input | 2 | Flag acknowledge, bit i clears timer i flag |
| gate_in | input | 2 | Gate pins, bit i for timer i |
| ext_in | input | 2 | External count pins, bit i for timer i |
| cfg_q | output | 8 | Configuration register |
| ctrl_q | output | 4 | Control register (run and flag bits) |
| cnt0 | output | 16 | Timer 0 count, high byte in bits 15:8 |
| cnt1 | output | 16 | Timer 1 count, high byte in bits 15:8 |
| ovf_pulse1 | output | 1 | One-clock pulse after each timer 1 overflow |

## Verification
Every count, flag and register update lands on the clock edge that follows the tick or write causing it, so it is visible one clock later. `ovf_pulse1` is registered one stage after the overflow, and flags appear in the same clock as the wrapped count. An external falling edge is counted on the second machine tick after the pin drops, because the sampler needs two samples. The bench runs its own tick, sampler and counter model on the same edges and compares all outputs on every falling clock edge, where outputs are settled. Its directed checks wait several whole tick periods, so a one-tick phase difference cannot hide an error.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_13    = 2'b00,
    MD_16    = 2'b01,
    MD_RLD   = 2'b10,
    MD_SPLIT = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext;
    tmr_mode_e md;
  } tmr_cfg_t;

  localparam logic [2:0] ADR_CFG  = 3'd0;
  localparam logic [2:0] ADR_CTRL = 3'd1;
  localparam int unsigned ADR_CNT_BASE = 2;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int unsigned TICK_DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_q;

  assign tick = (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_edge_sense.sv
module tmr_edge_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  logic smp_q, smp_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q   <= 1'b1;
      smp_d_q <= 1'b1;
    end else if (tick) begin
      smp_q   <= pin;
      smp_d_q <= smp_q;
    end
  end

  assign fall = tick & smp_d_q & ~smp_q;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned PRE_W    = 5,
  parameter bit          SPLIT_OK = 1'b1
) (
  input  tmr_mode_e         md,
  input  logic [BYTE_W-1:0] lo,
  input  logic [BYTE_W-1:0] hi,
  input  logic              en,
  input  logic              en_hi,
  output logic [BYTE_W-1:0] lo_n,
  output logic [BYTE_W-1:0] hi_n,
  output logic              ovf,
  output logic              ovf_hi
);
  always_comb begin
    lo_n   = lo;
    hi_n   = hi;
    ovf    = 1'b0;
    ovf_hi = 1'b0;
    unique case (md)
      MD_13: begin
        if (en) begin
          if (&lo[PRE_W-1:0]) begin
            lo_n[PRE_W-1:0] = '0;
            hi_n            = hi + 1'b1;
            ovf             = &hi;
          end else begin
            lo_n[PRE_W-1:0] = lo[PRE_W-1:0] + 1'b1;
          end
        end
      end
      MD_16: begin
        if (en) begin
          {hi_n, lo_n} = {hi, lo} + 1'b1;
          ovf          = &{hi, lo};
        end
      end
      MD_RLD: begin
        if (en) begin
          if (&lo) begin
            lo_n = hi;
            ovf  = 1'b1;
          end else begin
            lo_n = lo + 1'b1;
          end
        end
      end
      MD_SPLIT: begin
        if (SPLIT_OK) begin
          if (en) begin
            lo_n = lo + 1'b1;
            ovf  = &lo;
          end
          if (en_hi) begin
            hi_n   = hi + 1'b1;
            ovf_hi = &hi;
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int unsigned TICK_DIV = 12,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned PRE_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2:0]          wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [1:0]          ack,
  input  logic [1:0]          gate_in,
  input  logic [1:0]          ext_in,
  output logic [7:0]          cfg_q,
  output logic [3:0]          ctrl_q,
  output logic [2*BYTE_W-1:0] cnt0,
  output logic [2*BYTE_W-1:0] cnt1,
  output logic                ovf_pulse1
);
  localparam int unsigned NTMR = 2;

  logic tick;
  logic split0;
  logic [NTMR-1:0] ovf_main;
  logic [NTMR-1:0] ovf_hi;
  logic [NTMR-1:0][2*BYTE_W-1:0] cnt_all;

  tmr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  assign split0 = (tmr_mode_e'(cfg_q[1:0]) == MD_SPLIT);

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    localparam logic [2:0] A_LO = 3'(ADR_CNT_BASE + 2 * i);
    localparam logic [2:0] A_HI = 3'(ADR_CNT_BASE + 2 * i + 1);

    tmr_cfg_t          cfg;
    logic              fall, run_bit, allow, src, en, en_hi;
    logic [BYTE_W-1:0] lo_r, hi_r, lo_n, hi_n;
    logic              ovf, ovf_h;

    assign cfg = tmr_cfg_t'(cfg_q[4*i +: 4]);

    tmr_edge_sense u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .pin  (ext_in[i]),
      .fall (fall)
    );

    assign run_bit = (i == 1) ? (split0 | ctrl_q[2*i]) : ctrl_q[2*i];
    assign allow   = run_bit & (~cfg.gate | gate_in[i]);
    assign src     = cfg.ext ? fall : tick;
    assign en      = allow & src;
    assign en_hi   = (i == 0) ? (split0 & ctrl_q[2] & tick) : 1'b0;

    tmr_count_core #(
      .BYTE_W  (BYTE_W),
      .PRE_W   (PRE_W),
      .SPLIT_OK(i == 0)
    ) u_core (
      .md    (cfg.md),
      .lo    (lo_r),
      .hi    (hi_r),
      .en    (en),
      .en_hi (en_hi),
      .lo_n  (lo_n),
      .hi_n  (hi_n),
      .ovf   (ovf),
      .ovf_hi(ovf_h)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         lo_r <= '0;
      else if (wr_en && wr_addr == A_LO)  lo_r <= wr_data[BYTE_W-1:0];
      else                                lo_r <= lo_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         hi_r <= '0;
      else if (wr_en && wr_addr == A_HI)  hi_r <= wr_data[BYTE_W-1:0];
      else                                hi_r <= hi_n;
    end

    assign cnt_all[i]  = {hi_r, lo_r};
    assign ovf_main[i] = ovf;
    assign ovf_hi[i]   = ovf_h;
  end

  assign cnt0 = cnt_all[0];
  assign cnt1 = cnt_all[1];

  logic set0, set1;
  logic [3:0] ctrl_n;

  assign set0 = ovf_main[0];
  assign set1 = split0 ? ovf_hi[0] : ovf_main[1];

  always_comb begin
    ctrl_n = ctrl_q;
    if (wr_en && wr_addr == ADR_CTRL) ctrl_n = wr_data[3:0];
    if (ack[0]) ctrl_n[1] = 1'b0;
    if (ack[1]) ctrl_n[3] = 1'b0;
    if (set0)   ctrl_n[1] = 1'b1;
    if (set1)   ctrl_n[3] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      ctrl_q     <= '0;
      ovf_pulse1 <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADR_CFG) cfg_q <= wr_data;
      ctrl_q     <= ctrl_n;
      ovf_pulse1 <= ovf_main[1];
    end
  end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [7:0]  cfg_q,
  input logic [3:0]  ctrl_q,
  input logic [15:0] cnt0,
  input logic [15:0] cnt1,
  input logic        ovf_pulse1
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse1 |=> !ovf_pulse1); // R12

  AST_SPLIT_T1_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[5:4] == 2'b11 && !(wr_en && (wr_addr == 3'd4 || wr_addr == 3'd5)))
      |=> $stable(cnt1)); // R8

  AST_T0_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && cfg_q[1:0] != 2'b11 && !(wr_en && (wr_addr == 3'd2 || wr_addr == 3'd3)))
      |=> $stable(cnt0)); // R9

  AST_FLAG1_ON_T1_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse1 && $past(cfg_q[1:0]) != 2'b11) |-> ctrl_q[3]); // R11
endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .cfg_q     (cfg_q),
  .ctrl_q    (ctrl_q),
  .cnt0      (cnt0),
  .cnt1      (cnt1),
  .ovf_pulse1(ovf_pulse1)
);

// File: tb/tmr_pair_test.sv
module tmr_pair_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] ack = '0;
  logic [1:0] gate_in = '0;
  logic [1:0] ext_in = 2'b11;
  logic [7:0] cfg_q;
  logic [3:0] ctrl_q;
  logic [15:0] cnt0, cnt1;
  logic ovf_pulse1;

  int nvec = 0;
  int nfail = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_pair #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ack(ack), .gate_in(gate_in), .ext_in(ext_in), .cfg_q(cfg_q), .ctrl_q(ctrl_q),
    .cnt0(cnt0), .cnt1(cnt1), .ovf_pulse1(ovf_pulse1)
  );

  // ---------------- behavioural reference ----------------
  int m_div;
  bit [7:0] m_cfg;
  bit [3:0] m_ctl;
  bit [15:0] m_c0, m_c1;
  bit m_s0, m_sd0, m_s1, m_sd1, m_pls;

  function automatic bit [16:0] mstep(bit [1:0] md, bit [15:0] v, bit en);
    bit [7:0] lo = v[7:0];
    bit [7:0] hi = v[15:8];
    bit ov = 1'b0;
    if (en) begin
      case (md)
        2'd0: if (lo[4:0] == 5'd31) begin lo[4:0] = 5'd0; ov = (hi == 8'hFF); hi = hi + 8'd1; end
              else lo[4:0] = lo[4:0] + 5'd1;
        2'd1: begin ov = (v == 16'hFFFF); {hi, lo} = v + 16'd1; end
        2'd2: if (lo == 8'hFF) begin lo = hi; ov = 1'b1; end else lo = lo + 8'd1;
        default: ;
      endcase
    end
    return {ov, hi, lo};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div <= 0; m_cfg <= '0; m_ctl <= '0; m_c0 <= '0; m_c1 <= '0;
      m_s0 <= 1; m_sd0 <= 1; m_s1 <= 1; m_sd1 <= 1; m_pls <= 0;
    end else begin
      automatic bit tk = (m_div == DIV - 1);
      automatic bit split = (m_cfg[1:0] == 2'b11);
      automatic bit ev0 = tk && m_sd0 && !m_s0;
      automatic bit ev1 = tk && m_sd1 && !m_s1;
      automatic bit en0 = m_ctl[0] && (!m_cfg[3] || gate_in[0]) && (m_cfg[2] ? ev0 : tk);
      automatic bit en1 = (split || m_ctl[2]) && (!m_cfg[7] || gate_in[1]) && (m_cfg[6] ? ev1 : tk);
      automatic bit enh = split && m_ctl[2] && tk;
      automatic bit [16:0] r0, r1;
      automatic bit ov0, ovh, ov1;
      automatic bit [15:0] n0, n1;
      automatic bit [3:0] nc = m_ctl;
      if (split) begin
        n0 = m_c0; ov0 = 0; ovh = 0;
        if (en0) begin ov0 = (m_c0[7:0] == 8'hFF); n0[7:0] = m_c0[7:0] + 8'd1; end
        if (enh) begin ovh = (m_c0[15:8] == 8'hFF); n0[15:8] = m_c0[15:8] + 8'd1; end
      end else begin
        r0 = mstep(m_cfg[1:0], m_c0, en0); n0 = r0[15:0]; ov0 = r0[16]; ovh = 0;
      end
      if (m_cfg[5:4] == 2'b11) begin n1 = m_c1; ov1 = 0; end
      else begin r1 = mstep(m_cfg[5:4], m_c1, en1); n1 = r1[15:0]; ov1 = r1[16]; end
      if (wr_en && wr_addr == 3'd2) n0[7:0]  = wr_data;
      if (wr_en && wr_addr == 3'd3) n0[15:8] = wr_data;
      if (wr_en && wr_addr == 3'd4) n1[7:0]  = wr_data;
      if (wr_en && wr_addr == 3'd5) n1[15:8] = wr_data;
      if (wr_en && wr_addr == 3'd1) nc = wr_data[3:0];
      if (ack[0]) nc[1] = 0;
      if (ack[1]) nc[3] = 0;
      if (ov0) nc[1] = 1;
      if (split ? ovh : ov1) nc[3] = 1;
      if (wr_en && wr_addr == 3'd0) m_cfg <= wr_data;
      m_c0 <= n0; m_c1 <= n1; m_ctl <= nc; m_pls <= ov1;
      m_div <= tk ? 0 : m_div + 1;
      if (tk) begin m_s0 <= ext_in[0]; m_sd0 <= m_s0; m_s1 <= ext_in[1]; m_sd1 <= m_s1; end
    end
  end

  task automatic chk(string tag, int act, int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string mtag(bit [1:0] md);
    case (md)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R7";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 cfg", cfg_q, m_cfg);
      chk({mtag(m_cfg[1:0]), " cnt0"}, cnt0, m_c0);
      chk({mtag(m_cfg[5:4]), " cnt1"}, cnt1, m_c1);
      chk("R11 ctrl", ctrl_q, m_ctl);
      chk("R12 pulse", ovf_pulse1, m_pls);
      if (ovf_pulse1) pulses++;
    end
  end

  task automatic wr(bit [2:0] a, bit [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    automatic int snap;
    automatic int p0;
    idle(3);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    chk("R1 cnt0", cnt0, 0); chk("R1 cnt1", cnt1, 0);
    chk("R1 cfg", cfg_q, 0); chk("R1 ctrl", ctrl_q, 0); chk("R1 pulse", ovf_pulse1, 0);

    // R4 / R2: 16-bit mode, machine ticks
    wr(3'd0, 8'h11); wr(3'd2, 8'hFD); wr(3'd3, 8'hFF); wr(3'd1, 8'h01);
    idle(DIV * 5);
    chk("R4 flag0 after wrap", ctrl_q[1], 1);
    chk("R2 five ticks counted", cnt0, 16'h0002);

    // R11 ack and software clear
    @(negedge clk) ack = 2'b01;
    @(negedge clk) ack = 2'b00;
    chk("R11 ack clears flag0", ctrl_q[1], 0);
    wr(3'd1, 8'h0A);
    chk("R11 sw write flags", ctrl_q, 4'hA);
    wr(3'd1, 8'h00);
    chk("R11 sw clear", ctrl_q, 4'h0);

    // R3 13-bit mode
    wr(3'd0, 8'h10); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd1, 8'h01);
    idle(DIV * 4);
    chk("R3 upper low bits kept", cnt0[7:5], 3'b111);
    chk("R3 overflow flag", ctrl_q[1], 1);
    chk("R3 high wrapped", cnt0[15:8], 8'h00);

    // R5 reload
    wr(3'd1, 8'h00); wr(3'd0, 8'h12); wr(3'd3, 8'h80); wr(3'd2, 8'hFE); wr(3'd1, 8'h01);
    idle(DIV * 6);
    chk("R5 reload flag", ctrl_q[1], 1);
    chk("R5 high kept", cnt0[15:8], 8'h80);
    chk("R5 low reloaded", cnt0[7:0] >= 8'h80 && cnt0[7:0] < 8'h88, 1);

    // R9 gate
    wr(3'd1, 8'h00); wr(3'd0, 8'h19); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
    gate_in = 2'b00;
    idle(DIV * 5);
    chk("R9 gated low holds", cnt0, 0);
    gate_in = 2'b01;
    idle(DIV * 5);
    chk("R9 gate high counts", cnt0 >= 4, 1);
    gate_in = 2'b00;

    // R10 external falling edges
    wr(3'd0, 8'h15); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    idle(DIV * 3);
    for (int k = 0; k < 4; k++) begin
      ext_in[0] = 0; idle(DIV * 3);
      ext_in[0] = 1; idle(DIV * 3);
    end
    chk("R10 four edges", cnt0, 4);

    // R6 / R7 split mode
    wr(3'd1, 8'h00); wr(3'd0, 8'h13);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFE); wr(3'd4, 8'hFE); wr(3'd5, 8'hFF);
    wr(3'd1, 8'h05);
    idle(DIV * 4);
    chk("R6 low byte flag0", ctrl_q[1], 1);
    chk("R7 high byte flag1", ctrl_q[3], 1);
    p0 = pulses;
    wr(3'd1, 8'h01); wr(3'd4, 8'hFE); wr(3'd5, 8'hFF);
    snap = cnt0[15:8];
    idle(DIV * 4);
    chk("R7 t1 runs no run bit", cnt1 != 16'hFFFF, 1);
    chk("R7 t1 no flag1", ctrl_q[3], 0);
    chk("R12 pulse from t1", pulses - p0, 1);
    chk("R7 high byte stops", cnt0[15:8], snap);

    // R8 timer 1 in mode 3 holds
    wr(3'd0, 8'h31); wr(3'd1, 8'h04); wr(3'd4, 8'h55);
    snap = cnt1;
    idle(DIV * 4);
    chk("R8 t1 holds", cnt1, snap);

    idle(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule